// File: doc/BRIEF.md
# SPI Clock Divider Encoder

This block turns a requested SPI clock division ratio into the two-factor form used by a serial clock generator. The generator divides the core clock by a 4-bit mantissa times a power of two. The input is the smallest acceptable ratio, already rounded up by whoever computed it from the two frequencies. A one-cycle `start_i` launches a conversion. When the result is ready, `done_o` pulses for one cycle. The mantissa, the exponent and a packed configuration byte stay on the outputs until the next conversion finishes.

The encoder never picks a ratio below the one requested, so the resulting serial clock is never faster than asked. Large ratios are rounded up to the next value the mantissa and exponent can represent. The exponent is then found again, because the rounding can carry into a new top bit. If the exponent needed is larger than the 3-bit field can hold, the error flag is raised instead.

The interface is plain control: there is no back-pressure. A start pulse while `busy_o` is high is dropped. A start in the cycle where `done_o` is high is accepted.

Top module: `sck_div_encoder`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `spr_o`, `sppr_o` and `cfg_byte_o` are all zero.
- R2: A ratio from 1 to 15 gives `spr_o` equal to the ratio and `sppr_o` = 0. `done_o` is high in the second cycle after the start cycle.
- R3: A ratio of 0 is handled as a ratio of 1.
- R4: A ratio of 16 or more sets the exponent to (1-based position of its top set bit) minus 4. The ratio is rounded up to a multiple of 2^exponent, and `spr_o` is the rounded value shifted right by the exponent. The product `spr_o`·2^`sppr_o` is therefore the smallest representable value that is not below the request.
- R5: When rounding carries into a higher bit, the exponent is derived again from the rounded value. For example, 31 gives `spr_o`=8 and `sppr_o`=2.
- R6: If the final exponent exceeds 7, `err_o` is 1 with the done pulse, and `spr_o`, `sppr_o` and `cfg_byte_o` are 0. For example, 1921 and 2^32−1 raise the error, while 1920 gives 15 and 7.
- R7: The layout of `cfg_byte_o` is: bits 3:0 = `spr_o`, bit 4 = `sppr_o[0]`, bit 5 = 0, bits 7:6 = `sppr_o[2:1]`.
- R8: A ratio of 16 or more raises `done_o` in the fourth cycle after the start cycle. `done_o` is high for exactly one cycle, and `busy_o` is high from the cycle after start until the done cycle, but not during the done cycle itself.
- R9: A `start_i` while `busy_o` is high is ignored: the running conversion finishes with its own result, and nothing else follows.
- R10: The result outputs and `err_o` change only in a cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a conversion of `ratio_i` |
| ratio_i | input | 32 | Minimum division ratio |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Ratio not encodable |
| spr_o | output | 4 | Mantissa |
| sppr_o | output | 3 | Power-of-two exponent |
| cfg_byte_o | output | 8 | Packed configuration byte |

## Verification
The bench targets ratios just below a power of two, such as 31, 1023 and 2047. A design that skipped the second exponent search would report a 5-bit mantissa truncated to the wrong value, or miss the overflow into the error case. The boundary 1920/1921 and the all-ones ratio check the error flag, including the 33-bit carry that the rounding of the all-ones ratio produces. A design that rounded down would give a faster clock than asked, and the reference model catches this on every mismatching mantissa. Zero input, starts during busy and starts in the done cycle check that the input guard and the handling of ratio 0 neither corrupt nor drop a conversion.

// File: rtl/sck_div_pkg.sv
package sck_div_pkg;
  localparam int RATIO_W = 32;
  localparam int MANT_W  = 4;
  localparam int EXP_W   = 3;
  localparam int WORK_W  = RATIO_W + 1;
  localparam int IDX_W   = $clog2(WORK_W + 1);
  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int CFG_W   = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_ROUND,
    ST_RESCAN
  } enc_state_t;
endpackage

// File: rtl/sck_lead_one.sv
module sck_lead_one #(
  parameter int W  = 33,
  parameter int IW = 6
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] pos_o
);
  // 1-based index of the highest set bit, 0 when the vector is empty
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) pos_o = IW'(i + 1);
    end
  end
endmodule

// File: rtl/sck_round_up.sv
module sck_round_up #(
  parameter int W  = 33,
  parameter int IW = 6
) (
  input  logic [W-1:0]  val_i,
  input  logic [IW-1:0] exp_i,
  output logic [W-1:0]  val_o
);
  logic [W-1:0] low_mask;
  assign low_mask = (W'(1) << exp_i) - W'(1);
  // caller keeps the top bit clear, so the sum cannot wrap
  assign val_o = (val_i + low_mask) & ~low_mask;
endmodule

// File: rtl/sck_cfg_pack.sv
module sck_cfg_pack #(
  parameter int MW = 4,
  parameter int EW = 3,
  parameter int CW = 8
) (
  input  logic [MW-1:0] mant_i,
  input  logic [EW-1:0] exp_i,
  output logic [CW-1:0] cfg_o
);
  always_comb begin
    cfg_o = '0;
    cfg_o[MW-1:0] = mant_i;
    cfg_o[4]      = exp_i[0];
    cfg_o[7:6]    = exp_i[2:1];
  end
endmodule

// File: rtl/sck_div_encoder.sv
module sck_div_encoder
  import sck_div_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [MANT_W-1:0]  spr_o,
  output logic [EXP_W-1:0]   sppr_o,
  output logic [CFG_W-1:0]   cfg_byte_o
);
  enc_state_t        state_q;
  logic [WORK_W-1:0] work_q;
  logic [IDX_W-1:0]  exp_q;
  logic [IDX_W-1:0]  lead_pos;
  logic [IDX_W-1:0]  exp_now;
  logic [WORK_W-1:0] rounded;
  logic [WORK_W-1:0] shifted;
  logic              done_q, err_q;
  logic [MANT_W-1:0] spr_q;
  logic [EXP_W-1:0]  sppr_q;

  sck_lead_one #(.W(WORK_W), .IW(IDX_W)) u_lead (
    .vec_i (work_q),
    .pos_o (lead_pos)
  );

  sck_round_up #(.W(WORK_W), .IW(IDX_W)) u_round (
    .val_i (work_q),
    .exp_i (exp_q),
    .val_o (rounded)
  );

  assign exp_now = lead_pos - IDX_W'(MANT_W);
  assign shifted = work_q >> exp_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      work_q  <= '0;
      exp_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      spr_q   <= '0;
      sppr_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            work_q  <= (ratio_i == '0) ? WORK_W'(1) : {1'b0, ratio_i};
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (lead_pos <= IDX_W'(MANT_W)) begin
            spr_q   <= work_q[MANT_W-1:0];
            sppr_q  <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            exp_q   <= exp_now;
            state_q <= ST_ROUND;
          end
        end
        ST_ROUND: begin
          work_q  <= rounded;
          state_q <= ST_RESCAN;
        end
        ST_RESCAN: begin
          if (exp_now > IDX_W'(MAX_EXP)) begin
            spr_q  <= '0;
            sppr_q <= '0;
            err_q  <= 1'b1;
          end else begin
            spr_q  <= shifted[MANT_W-1:0];
            sppr_q <= exp_now[EXP_W-1:0];
            err_q  <= 1'b0;
          end
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sck_cfg_pack #(.MW(MANT_W), .EW(EXP_W), .CW(CFG_W)) u_pack (
    .mant_i (spr_q),
    .exp_i  (sppr_q),
    .cfg_o  (cfg_byte_o)
  );

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
  assign spr_o  = spr_q;
  assign sppr_o = sppr_q;
endmodule

// File: rtl/sck_div_encoder_chk.sv
module sck_div_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic [3:0] spr_o,
  input logic [2:0] sppr_o,
  input logic [7:0] cfg_byte_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                            // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);                                            // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));                                      // R8
  AST_ERR_CLEARS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (spr_o == 4'd0 && sppr_o == 3'd0 && cfg_byte_o == 8'd0)); // R6
  AST_MANT_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o && sppr_o != 3'd0) |-> spr_o >= 4'd8);        // R4
  AST_RESULT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> spr_o != 4'd0);                          // R3
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (done_o || ($stable(spr_o) && $stable(sppr_o) && $stable(err_o)))); // R10
endmodule

bind sck_div_encoder sck_div_encoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .spr_o      (spr_o),
  .sppr_o     (sppr_o),
  .cfg_byte_o (cfg_byte_o)
);

// File: tb/sck_div_encoder_tb.sv
module sck_div_encoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] ratio_i = '0;
  logic        busy_o, done_o, err_o;
  logic [3:0]  spr_o;
  logic [2:0]  sppr_o;
  logic [7:0]  cfg_byte_o;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  sck_div_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ratio_i(ratio_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .spr_o(spr_o), .sppr_o(sppr_o), .cfg_byte_o(cfg_byte_o)
  );

  // reference model state
  int   m_cnt = 0;
  bit   e_done = 0, e_err = 0;
  int   e_spr = 0, e_sppr = 0;
  int   p_spr, p_sppr;
  bit   p_err;

  function automatic int bitlen(longint unsigned x);
    int n = 0;
    while ((x >> n) != 0) n++;
    return n;
  endfunction

  task automatic ref_enc(input longint unsigned r_in, output int s, output int e,
                         output bit er, output int lat);
    longint unsigned r = (r_in == 0) ? 1 : r_in;
    longint unsigned step, r2;
    int e1;
    er = 0;
    if (r < 16) begin s = int'(r); e = 0; lat = 1; end
    else begin
      lat = 3;
      e1 = bitlen(r) - 4;
      step = longint'(1) << e1;
      r2 = ((r + step - 1) / step) * step;
      e = bitlen(r2) - 4;
      if (e > 7) begin er = 1; s = 0; e = 0; end
      else s = int'(r2 >> e);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; e_done = 0; e_err = 0; e_spr = 0; e_sppr = 0;
    end else begin
      e_done = 0;
      if (m_cnt == 1) begin
        m_cnt = 0; e_done = 1;
        e_spr = p_spr; e_sppr = p_sppr; e_err = p_err;
      end else if (m_cnt > 1) begin
        m_cnt--;
      end else if (start_i) begin
        ref_enc({32'd0, ratio_i}, p_spr, p_sppr, p_err, m_cnt);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy_o == (m_cnt != 0), "R8", "busy", int'(busy_o), int'(m_cnt != 0));
      chk(done_o == e_done, "R8", "done", int'(done_o), int'(e_done));
      chk(err_o == e_err, cur_req, "err", int'(err_o), int'(e_err));
      chk(int'(spr_o) == e_spr, cur_req, "spr", int'(spr_o), e_spr);
      chk(int'(sppr_o) == e_sppr, cur_req, "sppr", int'(sppr_o), e_sppr);
      chk(int'(cfg_byte_o) == (e_spr + (e_sppr % 2) * 16 + (e_sppr / 2) * 64),
          "R7", "cfg_byte", int'(cfg_byte_o),
          e_spr + (e_sppr % 2) * 16 + (e_sppr / 2) * 64);
    end
  end

  task automatic issue(input logic [31:0] r);
    @(negedge clk); start_i = 1'b1; ratio_i = r;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic settle();
    while (m_cnt != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [31:0] r, input string req);
    cur_req = req;
    issue(r);
    settle();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired, no requirement reached actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state checked at the ports while reset is held
    chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1", "ctrl", int'({busy_o, done_o, err_o}), 0);
    chk(spr_o == 0 && sppr_o == 0 && cfg_byte_o == 0, "R1", "data", int'(cfg_byte_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 small ratios pass through
    run(32'd1, "R2"); run(32'd7, "R2"); run(32'd15, "R2"); run(32'd2, "R2");
    // R3 zero behaves as one
    run(32'd0, "R3");
    // R4 rounding upward
    run(32'd16, "R4"); run(32'd17, "R4"); run(32'd100, "R4");
    run(32'd1000, "R4"); run(32'd1920, "R4");
    // R5 carry into a new top bit
    run(32'd31, "R5"); run(32'd1023, "R5"); run(32'd255, "R5");
    // R6 exponent overflow
    run(32'd1921, "R6"); run(32'd2047, "R6"); run(32'd4096, "R6"); run(32'hFFFF_FFFF, "R6");
    run(32'd9, "R6");
    // R7 every exponent value in the packed byte
    for (int k = 0; k < 8; k++) run(32'd9 << k, "R7");
    // R9 starts during busy are dropped
    cur_req = "R9";
    @(negedge clk); start_i = 1; ratio_i = 32'd500;
    @(negedge clk); ratio_i = 32'd3;
    @(negedge clk); ratio_i = 32'd4000;
    @(negedge clk); start_i = 0;
    settle();
    // R8 start taken in the done cycle
    cur_req = "R8";
    issue(32'd5);
    @(negedge clk); start_i = 1; ratio_i = 32'd77;
    @(negedge clk); start_i = 0;
    settle();
    // R10 pseudo-random sweep, outputs held between dones
    begin
      logic [31:0] lfsr = 32'h1234_5678;
      for (int i = 0; i < 40; i++) begin
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        run(lfsr >> (lfsr[4:0]), "R10");
        repeat (i % 3) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule